// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block sits between a set of interrupt sources (timers, I/O engines, program-error detectors, hardware-fault monitors) and the single interrupt input of a processor. Each source raises a request line. The controller holds each request in a pending bit until the processor accepts it. The processor sees one request signal and the identity of the chosen source. It answers with an acknowledge, which moves that source into service. It later reports the end of service.

A mode input selects one of two policies. In sequential mode, only one interrupt is in service at a time. Nothing else is forwarded until that service ends. Waiting sources are then handed over in the order in which they were raised. In nested mode, priority is fixed by line index, and index 0 is the highest. A request is forwarded only if it outranks every level that is already in service. When the preempting level ends, the level it interrupted becomes the highest active one again.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_out` is low, and no source is pending or in service.
- R2: A high `req_in[i]` at a clock edge makes source i pending. From the next cycle, while `irq_out` is high, `irq_id` names a pending source, and it stays there until that source is acknowledged.
- R3: In sequential mode (`mode_nested`=0), `irq_out` stays low while any source is in service, even if a higher-priority request is pending.
- R4: In sequential mode, `irq_id` is the pending source that was raised earliest. Sources raised at the same edge are ordered by lower index first.
- R5: A request from a source that is already pending does not change that source's place in the arrival order.
- R6: In nested mode (`mode_nested`=1), `irq_id` is the lowest-index pending source. `irq_out` is high only if that index is strictly lower than every in-service index, so an equal or lower priority is held back.
- R7: A high `eos_in` at a clock edge clears the in-service bit with the lowest index. The preempted level below it then becomes the one that gates further requests.
- R8: `ack_in` while `irq_out` is high clears the pending bit of `irq_id` and sets its in-service bit at the same edge. `ack_in` while `irq_out` is low has no effect.
- R9: If `req_in[i]` is high at the same edge at which source i is acknowledged, source i stays pending. It is then placed as the newest arrival.
- R10: In sequential mode, once the in-service source ends, the next pending source is forwarded in the cycle after `eos_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_nested | input | 1 | 0 = sequential mode, 1 = nested priority mode |
| req_in | input | NSRC | Request lines, one per source, sampled at each edge |
| ack_in | input | 1 | Processor accepts the forwarded request |
| eos_in | input | 1 | Processor has finished servicing the highest active level |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_id | output | IDW | Index of the forwarded source, valid while irq_out is high |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a source's acknowledge and a fresh request from that same source. The bench raises a source's line in the very cycle it acknowledges that source. After the service ends, it checks that the source is forwarded again, but only after an older waiting source. The second pair is an acknowledge and an end-of-service. These are driven together in nested mode, and the result is judged by whether later requests are held back by the newly set in-service level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int MAXSRC = 32;

  // Index of the lowest set bit, or MAXSRC when none is set.
  function automatic int first_set(logic [MAXSRC-1:0] v);
    int r;
    r = MAXSRC;
    for (int k = MAXSRC - 1; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

  // One-hot vector of the lowest set bit.
  function automatic logic [MAXSRC-1:0] lowest_bit(logic [MAXSRC-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           req_in,
  input  logic [NSRC-1:0]           clr_vec,
  output logic [NSRC-1:0]           pending_o,
  output logic [NSRC-1:0][NSRC-1:0] older_o
);
  logic [NSRC-1:0] pending_q;
  logic [NSRC-1:0] arrive_w;
  logic [NSRC-1:0] stay_w;

  assign stay_w   = pending_q & ~clr_vec;
  assign arrive_w = req_in & ~stay_w;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= stay_w | req_in;
  end

  // older_o[i][j] = source i was raised before source j
  for (genvar i = 0; i < NSRC; i++) begin : g_row
    for (genvar j = 0; j < NSRC; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_o[i][j] = 1'b0;
      end else begin : g_cell
        logic age_q;
        always_ff @(posedge clk) begin
          if (!rst_n)           age_q <= 1'b0;
          else if (arrive_w[j]) age_q <= stay_w[i] | (arrive_w[i] && (i < j));
          else if (arrive_w[i]) age_q <= 1'b0;
        end
        assign older_o[i][j] = age_q;
      end
    end
  end

  assign pending_o = pending_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDW  = 3
) (
  input  logic                      mode_nested,
  input  logic [NSRC-1:0]           pending,
  input  logic [NSRC-1:0][NSRC-1:0] older,
  input  logic [NSRC-1:0]           insvc,
  output logic                      irq,
  output logic [IDW-1:0]            id
);
  logic [NSRC-1:0] oldest_w;
  int seq_idx, pri_idx, svc_idx;

  for (genvar i = 0; i < NSRC; i++) begin : g_age
    logic [NSRC-1:0] col_w;
    for (genvar j = 0; j < NSRC; j++) begin : g_c
      assign col_w[j] = older[j][i];
    end
    assign oldest_w[i] = pending[i] & ~|(pending & col_w);
  end

  always_comb begin
    seq_idx = first_set(MAXSRC'(oldest_w));
    pri_idx = first_set(MAXSRC'(pending));
    svc_idx = first_set(MAXSRC'(insvc));
    if (mode_nested) begin
      irq = (|pending) && (pri_idx < svc_idx);
      id  = IDW'(pri_idx);
    end else begin
      irq = (|pending) && (insvc == '0);
      id  = IDW'(seq_idx);
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack
  import irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            eos_in,
  output logic [NSRC-1:0] insvc_o,
  output logic [NSRC-1:0] retire_o
);
  logic [NSRC-1:0] insvc_q;

  assign retire_o = eos_in ? NSRC'(lowest_bit(MAXSRC'(insvc_q))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) insvc_q <= '0;
    else        insvc_q <= (insvc_q & ~retire_o) | set_vec;
  end

  assign insvc_o = insvc_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC = 8,
  parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_nested,
  input  logic [NSRC-1:0] req_in,
  input  logic            ack_in,
  input  logic            eos_in,
  output logic            irq_out,
  output logic [IDW-1:0]  irq_id
);
  logic [NSRC-1:0]           pending_w;
  logic [NSRC-1:0][NSRC-1:0] older_w;
  logic [NSRC-1:0]           insvc_w;
  logic [NSRC-1:0]           retire_w;
  logic                      grant_w;
  logic [NSRC-1:0]           grant_vec;

  assign grant_w   = irq_out & ack_in;
  assign grant_vec = grant_w ? (NSRC'(1) << irq_id) : '0;

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr_vec(grant_vec),
    .pending_o(pending_w), .older_o(older_w)
  );

  irq_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
    .mode_nested(mode_nested), .pending(pending_w), .older(older_w),
    .insvc(insvc_w), .irq(irq_out), .id(irq_id)
  );

  irq_isr_stack #(.NSRC(NSRC)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_vec(grant_vec), .eos_in(eos_in),
    .insvc_o(insvc_w), .retire_o(retire_w)
  );
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NSRC = 8,
  parameter int IDW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_nested,
  input logic [NSRC-1:0] req_in,
  input logic            ack_in,
  input logic            eos_in,
  input logic            irq_out,
  input logic [IDW-1:0]  irq_id,
  input logic [NSRC-1:0] pending,
  input logic [NSRC-1:0] insvc,
  input logic [NSRC-1:0] retire
);
  logic [NSRC-1:0] upto_id;
  always_comb begin
    for (int k = 0; k < NSRC; k++) upto_id[k] = (k <= int'(irq_id));
  end

  // R2
  a_r2_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> pending[irq_id]);
  // R3
  a_r3_seq_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_nested && insvc != '0) |-> !irq_out);
  // R6
  a_r6_nest_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_nested && irq_out) |-> ((insvc & upto_id) == '0));
  // R8
  a_r8_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ack_in) |=> insvc[$past(irq_id)]);
  // R9
  a_r9_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ack_in && req_in[irq_id]) |=> pending[$past(irq_id)]);
  // R7
  a_r7_eos_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_in && insvc != '0 && !(irq_out && ack_in)) |=>
      ($countones(insvc) + 1 == $past($countones(insvc))));
  // R7
  a_r7_retire_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_nested(mode_nested), .req_in(req_in),
  .ack_in(ack_in), .eos_in(eos_in), .irq_out(irq_out), .irq_id(irq_id),
  .pending(pending_w), .insvc(insvc_w), .retire(retire_w)
);

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int IDW  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode_nested = 1'b0;
  logic [NSRC-1:0] req_in = '0;
  logic            ack_in = 1'b0;
  logic            eos_in = 1'b0;
  logic            irq_out;
  logic [IDW-1:0]  irq_id;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic           v;
    logic [IDW-1:0] id;
    string          tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl #(.NSRC(NSRC), .IDW(IDW)) u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_nested(mode_nested), .req_in(req_in),
    .ack_in(ack_in), .eos_in(eos_in), .irq_out(irq_out), .irq_id(irq_id)
  );

  // Monitor: compares outputs against the oldest expectation.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      tests++;
      if (irq_out !== e.v || (e.v && irq_id !== e.id)) begin
        fails++;
        $display("FAIL %s irq=%0b id=%0d expected irq=%0b id=%0d",
                 e.tag, irq_out, irq_id, e.v, e.id);
      end
    end
  end

  // Driver: applies one cycle of inputs and queues the outputs expected after that edge.
  task automatic step(input logic md, input logic [NSRC-1:0] rq, input logic ak,
                      input logic es, input logic ev, input int eid, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    mode_nested = md;
    req_in      = rq;
    ack_in      = ak;
    eos_in      = es;
    e.v   = ev;
    e.id  = IDW'(eid);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [NSRC-1:0] b(input int k);
    return NSRC'(1) << k;
  endfunction

  initial begin
    step(0, '0, 0, 0, 0, 0, "R1 reset");
    step(0, '0, 0, 0, 0, 0, "R1 reset");
    @(negedge clk); #1 rst_n = 1'b1;
    // sequential mode
    step(0, '0,        0, 0, 0, 0, "R1 idle after reset");
    step(0, b(5),      0, 0, 1, 5, "R2 request forwarded");
    step(0, b(3)|b(6), 0, 0, 1, 5, "R4 earlier arrival kept");
    step(0, b(5),      0, 0, 1, 5, "R5 re-request no change");
    step(0, '0,        1, 0, 0, 0, "R3 blocked in service");
    step(0, b(1),      0, 0, 0, 0, "R3 higher priority blocked");
    step(0, '0,        0, 1, 1, 3, "R10 next after end");
    step(0, '0,        1, 0, 0, 0, "R8 ack moves to service");
    step(0, '0,        0, 1, 1, 6, "R4 arrival order");
    step(0, b(6),      1, 0, 0, 0, "R9 ack with same request");
    step(0, '0,        0, 1, 1, 1, "R9 re-arrival is newest");
    step(0, '0,        1, 0, 0, 0, "R8 ack");
    step(0, '0,        0, 1, 1, 6, "R9 kept pending");
    step(0, '0,        1, 0, 0, 0, "R8 ack");
    step(0, '0,        0, 1, 0, 0, "R10 queue empty");
    step(0, '0,        1, 0, 0, 0, "R8 ack ignored when idle");
    step(0, b(4),      0, 0, 1, 4, "R8 stray ack left no service");
    // nested mode
    step(1, '0,        0, 0, 1, 4, "R6 nested forward");
    step(1, '0,        1, 0, 0, 0, "R8 nested ack");
    step(1, b(6),      0, 0, 0, 0, "R6 lower priority held");
    step(1, b(4),      0, 0, 0, 0, "R6 equal priority held");
    step(1, b(2),      0, 0, 1, 2, "R6 higher priority preempts");
    step(1, '0,        1, 0, 0, 0, "R6 held below two levels");
    step(1, b(0),      0, 0, 1, 0, "R6 top priority preempts");
    step(1, '0,        1, 0, 0, 0, "R8 third level in service");
    step(1, '0,        0, 1, 0, 0, "R7 end clears level 0 only");
    step(1, '0,        0, 1, 0, 0, "R7 end clears level 2 only");
    step(1, '0,        0, 1, 1, 4, "R7 resume after last level");
    step(1, '0,        1, 0, 0, 0, "R8 ack");
    step(1, '0,        0, 1, 1, 6, "R7 end releases next");
    step(1, '0,        1, 1, 0, 0, "R7 ack and end together");
    step(1, b(7),      0, 0, 0, 0, "R6 held by same-cycle grant");
    step(1, '0,        0, 1, 1, 7, "R7 end after same-cycle grant");
    step(1, '0,        0, 0, 1, 7, "R2 held until ack");
    @(negedge clk); #1;
    req_in = '0; ack_in = 1'b0; eos_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule